// File: doc/BRIEF.md
# Flash Security Gate with Backdoor Key

This block holds the security state of a small microcontroller's flash subsystem. It models a nonvolatile area. That area holds an eight-byte comparison key, a protection byte and an option byte. The working protection and option registers are refreshed from that area on every reset. The option byte carries a two-bit security field in bits [1:0] and a key-enable bit in bit 7. The device counts as secure unless the field holds the unsecure code 2'b10.

Code running from the user bus can unlock a secured part. It writes a candidate key one byte at a time, in index order, and then pulses a compare strobe. If the candidate equals the stored key, the device is unlocked until the next reset, and the stored option byte is left unchanged. Anything that arrives from the debug port is discarded. A wrong attempt locks the key path until the next reset. A mass-erase input rewrites the nonvolatile bytes to an unsecure, key-disabled state, and that state reaches the working registers at the following reset.

Top module: `fsec_ctrl`

## Requirements
- R1: On a clock edge with `rst` high, `opt_q` and `prot_q` load the nonvolatile option and protection bytes. On the same edge `unlocked` and `key_mismatch` clear.
- R2: `secure` is 1 unless `opt_q[1:0]` equals 2'b10 or `unlocked` is 1. `key_enabled` follows `opt_q[7]`.
- R3: Suppose `key_enabled` is 1 and eight user-bus byte writes with indices 0 through 7 are followed by a compare strobe. If every candidate byte equals the stored byte of the same index, `unlocked` rises and `secure` falls on the edge that samples the strobe. Both hold until reset, and `opt_q` does not change.
- R4: A key write or compare with `key_from_dbg` high has no effect. It never raises `unlocked` and never sets `key_mismatch`.
- R5: While `key_enabled` is 0, every key write and compare is ignored. A correct key leaves `unlocked` and `key_mismatch` at 0.
- R6: `key_mismatch` is set by any of three accepted events: a compare with a differing byte, a compare after fewer than eight bytes, or a write whose index is not the next expected one. The flag is sticky until reset. While it is set, every later key write and compare is refused.
- R7: A stored key whose bytes are all 8'h00, or all 8'hFF, never matches. A compare against such a key sets `key_mismatch`.
- R8: A `mass_erase` pulse sets the nonvolatile option byte's bits [1:0] to 2'b10 and its bit 7 to 0. It sets the protection byte and every key byte to 8'hFF. The working registers keep their values until the next reset.
- R9: A nonvolatile programming write goes to key byte i at address i (0 to 7), to the protection byte at address 8, and to the option byte at address 9. Such a write changes the working registers only at the next reset. If both arrive in the same cycle, mass erase wins.
- R10: A reset releases a previous unlock, and `secure` again follows the option byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads working registers |
| nv_pgm_en | input | 1 | Nonvolatile byte write strobe |
| nv_pgm_addr | input | 4 | Nonvolatile byte address (0-7 key, 8 protection, 9 option) |
| nv_pgm_data | input | 8 | Nonvolatile write data |
| mass_erase | input | 1 | Mass-erase pulse |
| key_wr_en | input | 1 | Candidate key byte write strobe |
| key_wr_idx | input | 3 | Candidate byte index |
| key_wr_data | input | 8 | Candidate byte value |
| key_cmp | input | 1 | Compare strobe |
| key_from_dbg | input | 1 | 1 marks the key write or compare as coming from the debug port |
| opt_q | output | 8 | Working option register |
| prot_q | output | 8 | Working protection register |
| key_enabled | output | 1 | Backdoor key enabled (working option bit 7) |
| secure | output | 1 | Security engaged |
| unlocked | output | 1 | Backdoor unlock active |
| key_mismatch | output | 1 | Sticky failed-attempt flag |

## Verification
The bench targets these corner cases:
- A correct key sent over the debug path. A design that trusted that path would unlock.
- A correct key with key-enable cleared. A design that skipped this gate would open a permanently disabled backdoor.
- Blank all-zero and all-ones keys entered as themselves. A design without this guard would unlock an erased part.
- A short sequence, an out-of-order index, and a correct key sent after a failure. A design without lockout or a byte counter would accept a partial or repeated search.
- Mass erase and nonvolatile writes checked both before and after a reset. A design that wrote straight into the working registers would change security in the middle of a session.

// File: rtl/fsec_pkg.sv
package fsec_pkg;
  localparam int BYTE_W        = 8;
  localparam int OPT_KEYEN_BIT = 7;
  localparam int SEC_LSB       = 0;
  localparam int SEC_W         = 2;
  localparam logic [SEC_W-1:0] SEC_OPEN_CODE = 2'b10;

  function automatic logic sec_field_open(input logic [BYTE_W-1:0] opt);
    return opt[SEC_LSB +: SEC_W] == SEC_OPEN_CODE;
  endfunction
endpackage

// File: rtl/fsec_nv_store.sv
module fsec_nv_store
  import fsec_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int ADDR_W    = 4,
  parameter logic [KEY_BYTES*BYTE_W-1:0] KEY_INIT = '0,
  parameter logic [BYTE_W-1:0] OPT_INIT  = 8'h80,
  parameter logic [BYTE_W-1:0] PROT_INIT = 8'hFF
) (
  input  logic                          clk,
  input  logic                          pgm_en,
  input  logic [ADDR_W-1:0]             pgm_addr,
  input  logic [BYTE_W-1:0]             pgm_data,
  input  logic                          mass_erase,
  output logic [KEY_BYTES*BYTE_W-1:0]   key_flat,
  output logic [BYTE_W-1:0]             nv_opt,
  output logic [BYTE_W-1:0]             nv_prot
);
  localparam int KEY_W = KEY_BYTES * BYTE_W;
  localparam logic [ADDR_W-1:0] ADDR_PROT = ADDR_W'(KEY_BYTES);
  localparam logic [ADDR_W-1:0] ADDR_OPT  = ADDR_W'(KEY_BYTES + 1);

  // Nonvolatile content: never touched by reset.
  logic [KEY_W-1:0]  key_r  = KEY_INIT;
  logic [BYTE_W-1:0] opt_r  = OPT_INIT;
  logic [BYTE_W-1:0] prot_r = PROT_INIT;

  always_ff @(posedge clk) begin
    if (mass_erase) begin
      key_r  <= '1;
      prot_r <= '1;
      opt_r  <= opt_r;
      opt_r[OPT_KEYEN_BIT]     <= 1'b0;
      opt_r[SEC_LSB +: SEC_W]  <= SEC_OPEN_CODE;
    end else if (pgm_en) begin
      for (int i = 0; i < KEY_BYTES; i++) begin
        if (pgm_addr == ADDR_W'(i)) key_r[i*BYTE_W +: BYTE_W] <= pgm_data;
      end
      if (pgm_addr == ADDR_PROT) prot_r <= pgm_data;
      if (pgm_addr == ADDR_OPT)  opt_r  <= pgm_data;
    end
  end

  assign key_flat = key_r;
  assign nv_opt   = opt_r;
  assign nv_prot  = prot_r;
endmodule

// File: rtl/fsec_key_entry.sv
module fsec_key_entry
  import fsec_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  localparam int IDX_W = $clog2(KEY_BYTES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enable,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic                        cmp,
  input  logic                        from_dbg,
  input  logic [KEY_BYTES*BYTE_W-1:0] stored_key,
  output logic                        hit,
  output logic                        mismatch_q
);
  localparam int KEY_W = KEY_BYTES * BYTE_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(KEY_BYTES);

  logic [BYTE_W-1:0] cand [KEY_BYTES];
  logic [CNT_W-1:0]  cnt_q;
  logic [KEY_BYTES-1:0] byte_eq;

  // Only the user bus, with the backdoor enabled and no prior failure, counts.
  logic accept;
  logic usr_wr, usr_cmp, in_order, blank, all_ok;

  assign accept   = enable && !from_dbg && !mismatch_q;
  assign usr_wr   = accept && wr_en;
  assign usr_cmp  = accept && cmp;
  assign in_order = ({1'b0, wr_idx} == cnt_q);

  genvar g;
  generate
    for (g = 0; g < KEY_BYTES; g++) begin : g_cmp
      assign byte_eq[g] = (cand[g] == stored_key[g*BYTE_W +: BYTE_W]);
    end
  endgenerate

  assign blank  = (stored_key == '0) || (stored_key == {KEY_W{1'b1}});
  assign all_ok = (&byte_eq) && (cnt_q == FULL) && !blank;
  assign hit    = usr_cmp && all_ok;

  // Candidate buffer carries no reset; it is qualified by the byte counter.
  always_ff @(posedge clk) begin
    if (usr_wr && in_order && !usr_cmp) cand[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      mismatch_q <= 1'b0;
    end else if (usr_cmp) begin
      if (!all_ok) mismatch_q <= 1'b1;
    end else if (usr_wr) begin
      if (in_order) cnt_q <= cnt_q + 1'b1;
      else          mismatch_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fsec_sec_state.sv
module fsec_sec_state
  import fsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] nv_opt,
  input  logic [BYTE_W-1:0] nv_prot,
  input  logic              hit,
  output logic [BYTE_W-1:0] opt_q,
  output logic [BYTE_W-1:0] prot_q,
  output logic              unlocked_q,
  output logic              secure_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q      <= nv_opt;
      prot_q     <= nv_prot;
      unlocked_q <= 1'b0;
      secure_q   <= !sec_field_open(nv_opt);
    end else if (hit) begin
      unlocked_q <= 1'b1;
      secure_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/fsec_ctrl.sv
module fsec_ctrl
  import fsec_pkg::*;
#(
  parameter int KEY_BYTES = 8,
  parameter int NV_ADDR_W = 4,
  parameter logic [KEY_BYTES*8-1:0] NV_KEY_INIT  = 64'h0123_4567_89AB_CDEF,
  parameter logic [7:0]             NV_OPT_INIT  = 8'h80,
  parameter logic [7:0]             NV_PROT_INIT = 8'hFF,
  localparam int IDX_W = $clog2(KEY_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nv_pgm_en,
  input  logic [NV_ADDR_W-1:0] nv_pgm_addr,
  input  logic [7:0]           nv_pgm_data,
  input  logic                 mass_erase,
  input  logic                 key_wr_en,
  input  logic [IDX_W-1:0]     key_wr_idx,
  input  logic [7:0]           key_wr_data,
  input  logic                 key_cmp,
  input  logic                 key_from_dbg,
  output logic [7:0]           opt_q,
  output logic [7:0]           prot_q,
  output logic                 key_enabled,
  output logic                 secure,
  output logic                 unlocked,
  output logic                 key_mismatch
);
  logic [KEY_BYTES*BYTE_W-1:0] key_flat;
  logic [BYTE_W-1:0] nv_opt, nv_prot;
  logic hit;

  fsec_nv_store #(
    .KEY_BYTES(KEY_BYTES), .ADDR_W(NV_ADDR_W),
    .KEY_INIT(NV_KEY_INIT), .OPT_INIT(NV_OPT_INIT), .PROT_INIT(NV_PROT_INIT)
  ) nv_i (
    .clk(clk), .pgm_en(nv_pgm_en), .pgm_addr(nv_pgm_addr), .pgm_data(nv_pgm_data),
    .mass_erase(mass_erase), .key_flat(key_flat), .nv_opt(nv_opt), .nv_prot(nv_prot)
  );

  fsec_key_entry #(.KEY_BYTES(KEY_BYTES)) ke_i (
    .clk(clk), .rst(rst),
    .enable(opt_q[OPT_KEYEN_BIT] && !unlocked),
    .wr_en(key_wr_en), .wr_idx(key_wr_idx), .wr_data(key_wr_data),
    .cmp(key_cmp), .from_dbg(key_from_dbg), .stored_key(key_flat),
    .hit(hit), .mismatch_q(key_mismatch)
  );

  fsec_sec_state st_i (
    .clk(clk), .rst(rst), .nv_opt(nv_opt), .nv_prot(nv_prot), .hit(hit),
    .opt_q(opt_q), .prot_q(prot_q), .unlocked_q(unlocked), .secure_q(secure)
  );

  assign key_enabled = opt_q[OPT_KEYEN_BIT];
endmodule

// File: rtl/fsec_ctrl_chk.sv
module fsec_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       key_cmp,
  input logic       key_from_dbg,
  input logic [7:0] opt_q,
  input logic [7:0] prot_q,
  input logic       key_enabled,
  input logic       secure,
  input logic       unlocked,
  input logic       key_mismatch
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!unlocked && !key_mismatch)); // R1
  AST_SECURE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && opt_q[1:0] != 2'b10) |-> secure); // R2
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (rst) unlocked |-> !secure); // R3
  AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) unlocked |=> unlocked); // R10
  AST_DBG_NO_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && key_cmp && key_from_dbg) |=> !unlocked); // R4
  AST_KEYEN_GATE: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !key_enabled) |=> !unlocked); // R5
  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    key_mismatch |=> key_mismatch); // R6
  AST_MISMATCH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (key_mismatch && !unlocked) |=> !unlocked); // R6
  AST_WORKING_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(opt_q) && $stable(prot_q))); // R9
endmodule

bind fsec_ctrl fsec_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .key_cmp(key_cmp), .key_from_dbg(key_from_dbg),
  .opt_q(opt_q), .prot_q(prot_q), .key_enabled(key_enabled), .secure(secure),
  .unlocked(unlocked), .key_mismatch(key_mismatch)
);

// File: tb/fsec_ctrl_tb_top.sv
`timescale 1ns/1ps
module fsec_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nv_pgm_en = 1'b0;
  logic [3:0] nv_pgm_addr = '0;
  logic [7:0] nv_pgm_data = '0;
  logic       mass_erase = 1'b0;
  logic       key_wr_en = 1'b0;
  logic [2:0] key_wr_idx = '0;
  logic [7:0] key_wr_data = '0;
  logic       key_cmp = 1'b0;
  logic       key_from_dbg = 1'b0;
  logic [7:0] opt_q, prot_q;
  logic       key_enabled, secure, unlocked, key_mismatch;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fsec_ctrl dut_i (
    .clk(clk), .rst(rst), .nv_pgm_en(nv_pgm_en), .nv_pgm_addr(nv_pgm_addr),
    .nv_pgm_data(nv_pgm_data), .mass_erase(mass_erase), .key_wr_en(key_wr_en),
    .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data), .key_cmp(key_cmp),
    .key_from_dbg(key_from_dbg), .opt_q(opt_q), .prot_q(prot_q),
    .key_enabled(key_enabled), .secure(secure), .unlocked(unlocked),
    .key_mismatch(key_mismatch)
  );

  typedef struct packed {
    logic [63:0] key;
    logic [7:0]  opt;
    logic [63:0] entry;
    logic        dbg;
    logic        exp_unl;
    logic        exp_mm;
    logic        exp_sec;
  } vec_t;

  localparam logic [63:0] KA = 64'h8877_6655_4433_2211;
  localparam logic [63:0] KB = 64'h0F1E_2D3C_4B5A_6978;

  localparam vec_t VECS [8] = '{
    '{KA, 8'h80, KA, 1'b0, 1'b1, 1'b0, 1'b0},                    // R3 correct key
    '{KA, 8'h80, 64'h8977_6655_4433_2211, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 bad top byte
    '{KA, 8'h80, KA, 1'b1, 1'b0, 1'b0, 1'b1},                    // R4 debug path
    '{KA, 8'h00, KA, 1'b0, 1'b0, 1'b0, 1'b1},                    // R5 key disabled
    '{64'h0, 8'h80, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1},              // R7 all zeros
    '{{64{1'b1}}, 8'h80, {64{1'b1}}, 1'b0, 1'b0, 1'b1, 1'b1},    // R7 all ones
    '{KB, 8'h82, KB, 1'b0, 1'b1, 1'b0, 1'b0},                    // R3 unsecure field
    '{KB, 8'h82, KA, 1'b0, 1'b0, 1'b1, 1'b0}                     // R2 open code, bad key
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic nv_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); nv_pgm_en = 1'b1; nv_pgm_addr = a; nv_pgm_data = d;
    @(negedge clk); nv_pgm_en = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic key_write(input int idx, input logic [7:0] d, input logic dbg);
    @(negedge clk); key_wr_en = 1'b1; key_wr_idx = 3'(idx); key_wr_data = d; key_from_dbg = dbg;
    @(negedge clk); key_wr_en = 1'b0; key_from_dbg = 1'b0;
  endtask

  task automatic key_compare(input logic dbg);
    @(negedge clk); key_cmp = 1'b1; key_from_dbg = dbg;
    @(negedge clk); key_cmp = 1'b0; key_from_dbg = 1'b0;
  endtask

  task automatic load_key(input logic [63:0] k, input logic [7:0] opt);
    for (int i = 0; i < 8; i++) nv_write(4'(i), k[i*8 +: 8]);
    nv_write(4'd9, opt);
  endtask

  task automatic enter_key(input logic [63:0] k, input int n, input logic dbg);
    for (int i = 0; i < n; i++) key_write(i, k[i*8 +: 8], dbg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state with programmed bytes
    load_key(KA, 8'h81);
    nv_write(4'd8, 8'h5A);
    pulse_reset();
    check("R1 opt", opt_q, 8'h81);
    check("R1 prot", prot_q, 8'h5A);
    check("R1 unlocked", {7'd0, unlocked}, 8'd0);
    check("R1 mismatch", {7'd0, key_mismatch}, 8'd0);
    check("R2 key_enabled", {7'd0, key_enabled}, 8'd1);
    check("R2 secure", {7'd0, secure}, 8'd1);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      load_key(VECS[v].key, VECS[v].opt);
      pulse_reset();
      enter_key(VECS[v].entry, 8, VECS[v].dbg);
      key_compare(VECS[v].dbg);
      check($sformatf("vec%0d unlocked R3", v), {7'd0, unlocked}, {7'd0, VECS[v].exp_unl});
      check($sformatf("vec%0d mismatch R6", v), {7'd0, key_mismatch}, {7'd0, VECS[v].exp_mm});
      check($sformatf("vec%0d secure R2", v), {7'd0, secure}, {7'd0, VECS[v].exp_sec});
      check($sformatf("vec%0d opt R3", v), opt_q, VECS[v].opt);
    end

    // R10: reset drops unlock
    load_key(KA, 8'h80);
    pulse_reset();
    enter_key(KA, 8, 1'b0);
    key_compare(1'b0);
    check("R3 unlock before reset", {7'd0, unlocked}, 8'd1);
    pulse_reset();
    check("R10 unlocked after reset", {7'd0, unlocked}, 8'd0);
    check("R10 secure after reset", {7'd0, secure}, 8'd1);

    // R6: out-of-order index
    key_write(1, 8'h22, 1'b0);
    check("R6 out of order", {7'd0, key_mismatch}, 8'd1);

    // R6: short sequence
    pulse_reset();
    enter_key(KA, 7, 1'b0);
    check("R6 no flag before compare", {7'd0, key_mismatch}, 8'd0);
    key_compare(1'b0);
    check("R6 short sequence", {7'd0, key_mismatch}, 8'd1);

    // R6: lockout after failure
    pulse_reset();
    enter_key(KB, 8, 1'b0);
    key_compare(1'b0);
    check("R6 wrong key", {7'd0, key_mismatch}, 8'd1);
    enter_key(KA, 8, 1'b0);
    key_compare(1'b0);
    check("R6 lockout unlocked", {7'd0, unlocked}, 8'd0);
    check("R6 lockout secure", {7'd0, secure}, 8'd1);

    // R9: NV write does not reach working regs before reset
    pulse_reset();
    nv_write(4'd9, 8'h82);
    check("R9 opt held", opt_q, 8'h80);
    check("R9 secure held", {7'd0, secure}, 8'd1);
    pulse_reset();
    check("R9 opt after reset", opt_q, 8'h82);
    check("R9 secure after reset", {7'd0, secure}, 8'd0);

    // R9: mass erase wins over a same-cycle programming write
    load_key(KA, 8'h80);
    nv_write(4'd8, 8'h33);
    @(negedge clk);
    mass_erase = 1'b1; nv_pgm_en = 1'b1; nv_pgm_addr = 4'd9; nv_pgm_data = 8'h81;
    @(negedge clk);
    mass_erase = 1'b0; nv_pgm_en = 1'b0;
    pulse_reset();
    check("R9 erase priority opt", opt_q, 8'h02);

    // R8: mass erase, visible only after reset
    load_key(KA, 8'h80);
    nv_write(4'd8, 8'h5A);
    pulse_reset();
    @(negedge clk); mass_erase = 1'b1;
    @(negedge clk); mass_erase = 1'b0;
    check("R8 opt held", opt_q, 8'h80);
    check("R8 prot held", prot_q, 8'h5A);
    pulse_reset();
    check("R8 opt erased", opt_q, 8'h02);
    check("R8 prot erased", prot_q, 8'hFF);
    check("R8 key disabled", {7'd0, key_enabled}, 8'd0);
    check("R8 unsecure", {7'd0, secure}, 8'd0);
    enter_key({64{1'b1}}, 8, 1'b0);
    key_compare(1'b0);
    check("R5 erased key ignored unl", {7'd0, unlocked}, 8'd0);
    check("R5 erased key ignored mm", {7'd0, key_mismatch}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule